// File: doc/BRIEF.md
# Conditional Branch Resolver with Delay-Slot Squash

This block resolves a conditional branch for a core that has one architectural delay slot after every control transfer. Each clock it takes an instruction word, the address of that instruction and the four integer condition flags (negative, zero, overflow, carry). From these it works out four things: whether the branch goes, where it goes, which address to fetch once the delay slot is done, and whether the delay-slot instruction must be squashed.

Sixteen tests are selected by a 4-bit condition code. The eight upper codes are the logical inverses of the eight lower ones. The squash rule is asymmetric. A branch whose annul bit is set squashes its delay slot when it falls through. An unconditional branch with the annul bit set also squashes the slot. Every other taken branch keeps the slot. The results are registered once, so each output shows the decision for the inputs sampled at the previous rising edge.

Top module: `branch_resolver`

## Requirements
- R1: While reset is asserted, `taken`, `annul`, `target` and `next_fetch` are all zero.
- R2: The condition code is `insn[28:25]`. Codes 0 to 7 test, in order: never, Z, Z|(N^V), N^V, C|Z, C, N, V.
- R3: Each code 8 to 15 yields the inverse of the code eight below it. Code 8 is always taken.
- R4: `target` equals `pc` plus four times `insn[21:0]`, with that field sign-extended from bit 21 and the sum taken modulo 2^ADDR_W.
- R5: For an untaken branch with the annul bit `insn[29]` set, `annul` is 1 and `next_fetch` is `pc`+8.
- R6: For an untaken branch with `insn[29]` clear, `annul` is 0 and `next_fetch` is `pc`+8.
- R7: For code 8 with `insn[29]` set, `taken` is 1, `annul` is 1 and `next_fetch` equals `target`.
- R8: For any other taken branch, `annul` is 0 and `next_fetch` equals `target`.
- R9: The word is a branch only when `insn[31:30]` is 00 and `insn[24:22]` is 010. For any other word, `taken` and `annul` are 0 and `next_fetch` is `pc`+8.
- R10: The outputs change only at a rising clock edge. Each update reflects the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn | input | 32 | Instruction word under resolution |
| pc | input | ADDR_W | Address of that instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| taken | output | 1 | Branch goes to target |
| annul | output | 1 | Squash the delay-slot instruction |
| target | output | ADDR_W | Branch destination |
| next_fetch | output | ADDR_W | Address to fetch after the delay slot |

## Verification
The assertions assume that the inputs are stable and known at each rising edge after reset is released. They also assume the flags are independent single bits with no encoding between them. The bench changes every input on the falling edge only and gives every input a defined value, including the bits of non-branch words. Random words are forced into the branch encoding most of the time and left free the rest of the time, so that both the valid path and the rejected path are exercised under the same assumptions.

// File: rtl/brres_pkg.sv
package brres_pkg;
    localparam int INSN_W     = 32;
    localparam int DISP_W     = 22;
    localparam int COND_W     = 4;
    localparam int NUM_CONDS  = 1 << COND_W;
    localparam int COND_LSB   = 25;
    localparam int ANNUL_BIT  = 29;
    localparam int FMT_MSB    = 31;
    localparam int FMT_LSB    = 30;
    localparam int SUB_MSB    = 24;
    localparam int SUB_LSB    = 22;
    localparam logic [1:0] FMT_BRANCH = 2'b00;
    localparam logic [2:0] SUB_ICC    = 3'b010;

    typedef enum logic [COND_W-1:0] {
        C_NEVER = 4'd0, C_EQ  = 4'd1, C_LE  = 4'd2, C_LT  = 4'd3,
        C_LEU   = 4'd4, C_CS  = 4'd5, C_NEG = 4'd6, C_VS  = 4'd7,
        C_ALWAYS = 4'd8, C_NE = 4'd9, C_GT  = 4'd10, C_GE = 4'd11,
        C_GTU   = 4'd12, C_CC = 4'd13, C_POS = 4'd14, C_VC = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
    import brres_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic              is_branch,
    output cond_e             cond,
    output logic              annul_bit,
    output logic [DISP_W-1:0] disp
);
    always_comb begin
        is_branch = (insn[FMT_MSB:FMT_LSB] == FMT_BRANCH) &&
                    (insn[SUB_MSB:SUB_LSB] == SUB_ICC);
        cond      = cond_e'(insn[COND_LSB +: COND_W]);
        annul_bit = insn[ANNUL_BIT];
        disp      = insn[DISP_W-1:0];
    end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import brres_pkg::*;
(
    input  flags_t flags,
    input  cond_e  cond,
    output logic   pass
);
    localparam int HALF = NUM_CONDS / 2;

    logic [NUM_CONDS-1:0] truth;

    function automatic logic base_test(input int code, input flags_t f);
        case (code)
            0: base_test = 1'b0;
            1: base_test = f.z;
            2: base_test = f.z | (f.n ^ f.v);
            3: base_test = f.n ^ f.v;
            4: base_test = f.c | f.z;
            5: base_test = f.c;
            6: base_test = f.n;
            default: base_test = f.v;
        endcase
    endfunction

    for (genvar k = 0; k < NUM_CONDS; k++) begin : g_code
        if (k < HALF) begin : g_lo
            assign truth[k] = base_test(k, flags);
        end else begin : g_hi
            assign truth[k] = ~base_test(k - HALF, flags);
        end
    end

    assign pass = truth[cond];
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
    import brres_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq_after_slot
);
    localparam int EXT_W = ADDR_W - DISP_W - 2;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset         = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
        target         = pc + offset;
        seq_after_slot = pc + ADDR_W'(8);
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
    import brres_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn,
    input  logic [ADDR_W-1:0] pc,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    output logic              taken,
    output logic              annul,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_fetch
);
    typedef struct packed {
        logic              taken;
        logic              annul;
        logic [ADDR_W-1:0] target;
        logic [ADDR_W-1:0] next_fetch;
    } res_t;

    res_t res_d, res_q;
    logic seen_q;

    logic              is_branch;
    cond_e             cond;
    logic              annul_bit;
    logic [DISP_W-1:0] disp;
    logic              pass;
    logic [ADDR_W-1:0] tgt;
    logic [ADDR_W-1:0] seq;
    flags_t            flags;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    br_decode u_dec (
        .insn      (insn),
        .is_branch (is_branch),
        .cond      (cond),
        .annul_bit (annul_bit),
        .disp      (disp)
    );

    br_cond_eval u_cond (
        .flags (flags),
        .cond  (cond),
        .pass  (pass)
    );

    br_target_calc #(.ADDR_W(ADDR_W)) u_tgt (
        .pc             (pc),
        .disp           (disp),
        .target         (tgt),
        .seq_after_slot (seq)
    );

    always_comb begin
        res_d        = '0;
        res_d.target = tgt;
        res_d.taken  = is_branch & pass;
        if (!is_branch) begin
            res_d.annul = 1'b0;
        end else if (!pass) begin
            res_d.annul = annul_bit;
        end else begin
            res_d.annul = annul_bit & (cond == C_ALWAYS);
        end
        res_d.next_fetch = res_d.taken ? tgt : seq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            res_q  <= res_d;
            seen_q <= 1'b1;
        end
    end

    assign taken      = res_q.taken;
    assign annul      = res_q.annul;
    assign target     = res_q.target;
    assign next_fetch = res_q.next_fetch;

    // R2
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(cond == C_NEVER) |-> !taken);
    // R3
    always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(is_branch && cond == C_ALWAYS) |-> taken);
    // R9
    non_branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(!is_branch) |-> !taken && !annul);
    // R8
    taken_goes_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> next_fetch == target);
    // R6
    fallthrough_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !taken |-> next_fetch == $past(pc) + ADDR_W'(8));
    // R7
    taken_squash_only_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && taken && annul |-> $past(cond) == C_ALWAYS);
    // R5
    squash_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && annul |-> $past(insn[ANNUL_BIT]));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> !taken && !annul);
endmodule

// File: tb/branch_resolver_test.sv
`timescale 1ns/1ps
module branch_resolver_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   insn = '0;
    logic [AW-1:0] pc = '0;
    logic          flag_n = 0, flag_z = 0, flag_v = 0, flag_c = 0;
    logic          taken, annul;
    logic [AW-1:0] target, next_fetch;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    branch_resolver #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .insn(insn), .pc(pc),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .taken(taken), .annul(annul), .target(target), .next_fetch(next_fetch)
    );

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_pass(input int code, input bit n, input bit z,
                                    input bit v, input bit c);
        bit b;
        case (code % 8)
            0: b = 0;
            1: b = z;
            2: b = z | (n ^ v);
            3: b = n ^ v;
            4: b = c | z;
            5: b = c;
            6: b = n;
            default: b = v;
        endcase
        return (code >= 8) ? !b : b;
    endfunction

    function automatic logic [AW-1:0] exp_target(input logic [31:0] w,
                                                 input logic [AW-1:0] p);
        logic signed [AW-1:0] d;
        d = AW'(signed'(w[21:0]));
        return p + AW'(d * 4);
    endfunction

    function automatic logic [31:0] mk(input bit a, input int code,
                                       input logic [21:0] disp);
        return {2'b00, a, 4'(code), 3'b010, disp};
    endfunction

    // drive on a falling edge, check on the next falling edge
    task automatic run_vec(input logic [31:0] w, input logic [AW-1:0] p,
                           input logic [3:0] f);
        bit valid, pass_e, a, tk, an;
        int code;
        logic [AW-1:0] tg, nf;
        string rq;
        @(negedge clk);
        insn = w; pc = p;
        {flag_n, flag_z, flag_v, flag_c} = f;
        @(negedge clk);
        valid  = (w[31:30] == 2'b00) && (w[24:22] == 3'b010);
        code   = int'(w[28:25]);
        a      = w[29];
        pass_e = exp_pass(code, f[3], f[2], f[1], f[0]);
        tk     = valid && pass_e;
        an     = valid && a && (!pass_e || code == 8);
        tg     = exp_target(w, p);
        nf     = tk ? tg : p + 8;
        if (!valid) rq = "R9";
        else if (code < 8) rq = "R2";
        else rq = "R3";
        chk(rq, "taken", AW'(taken), AW'(tk));
        if (!valid) rq = "R9";
        else if (!tk && a) rq = "R5";
        else if (!tk) rq = "R6";
        else if (a && code == 8) rq = "R7";
        else rq = "R8";
        chk(rq, "annul", AW'(annul), AW'(an));
        chk(rq, "next_fetch", next_fetch, nf);
        chk("R4", "target", target, tg);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] w;
        logic [AW-1:0] held_next;
        void'($urandom(32'h5EED_0042));
        insn = mk(1'b1, 8, 22'h000010);
        pc   = 32'h0000_4000;
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held despite active inputs
        chk("R1", "taken", AW'(taken), '0);
        chk("R1", "annul", AW'(annul), '0);
        chk("R1", "target", target, '0);
        chk("R1", "next_fetch", next_fetch, '0);
        rst_n = 1'b1;

        // full sweep: 16 codes x 16 flag patterns x annul on/off
        for (int a = 0; a < 2; a++)
            for (int c = 0; c < 16; c++)
                for (int f = 0; f < 16; f++)
                    run_vec(mk(a[0], c, 22'($urandom)), 32'h1000_0000 + 32'(f * 64),
                            4'(f));

        // R4 displacement corners
        run_vec(mk(1'b0, 8, 22'h1FFFFF), 32'h0000_2000, 4'h0);
        run_vec(mk(1'b0, 8, 22'h200000), 32'h0100_0000, 4'h0);
        run_vec(mk(1'b0, 8, 22'h3FFFFF), 32'h0000_0000, 4'h0);
        run_vec(mk(1'b0, 8, 22'h000001), 32'hFFFF_FFFC, 4'h0);
        run_vec(mk(1'b1, 0, 22'h000000), 32'hFFFF_FFFC, 4'hF);

        // R9 non-branch words with fields that would otherwise branch
        run_vec(32'h50800010, 32'h0000_3000, 4'h0);
        run_vec(32'hB0800010, 32'h0000_3000, 4'h0);
        run_vec(32'h30C00010, 32'h0000_3000, 4'h0);
        run_vec(32'h31800010, 32'h0000_3000, 4'h0);

        // R10: new inputs do not show before the next rising edge
        run_vec(mk(1'b0, 8, 22'h000100), 32'h0000_8000, 4'h0);
        held_next = next_fetch;
        @(negedge clk);
        insn = mk(1'b0, 0, 22'h000100);
        #5;
        chk("R10", "next_fetch held", next_fetch, held_next);
        chk("R10", "taken held", AW'(taken), AW'(1));
        @(negedge clk);
        chk("R10", "next_fetch updated", next_fetch, 32'h0000_8008);

        // random mix, mostly valid encodings
        for (int i = 0; i < 400; i++) begin
            w = $urandom;
            if ($urandom_range(0, 3) != 0) begin
                w[31:30] = 2'b00;
                w[24:22] = 3'b010;
            end
            run_vec(w, $urandom, 4'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule